// File: doc/BRIEF.md
# I2C Target Interface

This block lets a processor join an I2C bus as a target device with a 7-bit address. Firmware programs the address, enables the interface and then services events through one byte-wide data register. When a master addresses the block, it acknowledges the address and records the transfer direction. In a write transfer, each incoming byte is placed in the data register. In a read transfer, each outgoing byte is taken from that register. After every byte, the block holds SCL low until firmware has dealt with the data register. That pause is what keeps the bus in step with software.

Events are kept in a status register. An interrupt output is raised from the status flags that are enabled. Firmware acknowledges an event by writing a zero to its bit. A control bit lets firmware refuse each received byte with a NACK. Responding to the general-call address is optional.

Register offsets on the register bus: 0 control, 1 status, 2 interrupt enable, 3 own address, 4 data. The bus pins are open-drain: an `_oe` output at 1 pulls the line low.

Top module: `i2c_target`

## Requirements
- R1: After reset, every register reads 0, both open-drain drivers are released and the interrupt output is low.
- R2: With the interface enabled (control bit2), an address byte whose upper seven bits equal the own-address register (offset 3) is ACKed. It sets status bit0 (address received), and status bit5 (transmit mode) takes the byte's bit0 (1 means the master reads).
- R3: An address byte that does not match is NACKed, sets no address flag and causes no SCL stretching.
- R4: In a write transfer, each received byte is stored in the data register (offset 4) and sets status bit1. SCL is held low until firmware reads the data register.
- R5: After a received byte is released, the byte is ACKed when control bit0 (forced NACK) is 0 and NACKed when it is 1. The address byte is always ACKed.
- R6: In a read transfer, SCL is held low after the address ACK until firmware writes the data register. That byte is then sent MSB first.
- R7: Every byte sent sets status bit2 (data transmitted). A master ACK also sets status bit3 (data empty), and SCL is held low again until the next data write.
- R8: A master NACK ends the read transfer. SDA is released and no further stretching occurs, and status bit3 is not set.
- R9: Any STOP on the bus sets status bit4, including STOPs that end transfers addressed to other devices.
- R10: The general-call byte 0x00 is ACKed only when control bit1 is set. It then sets status bit6 and bit0, with bit5 cleared.
- R11: A write to the status register clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. Bit5 follows the transfer direction and is not changed by writes.
- R12: The interrupt output is high exactly when some status bit and the same interrupt-enable bit (offset 2) are both 1.
- R13: With control bit2 at 0, the block ignores the bus: it sets no flags and drives neither line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (side effect only on the data register) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default two-stage line synchronizer. It models the bus as a wired-AND of its own master and the block's drivers. Its master runs an SCL half period of ten system clocks, so the synchronizer latency stays well inside each SCL phase. This lets the bench observe at the pins the ACK slots, the stretching windows and the START/STOP detection. Because every bus action is a separate step, firmware servicing can be placed between the eighth clock and the ACK slot. The bench can then hold a stretch open for an arbitrary time.

// File: rtl/i2c_target.sv
`timescale 1ns/1ps
module i2c_target #(
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_IEN = 3'd2, A_OWN = 3'd3, A_DATA = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_ADDR = 4'd1, S_AACK = 4'd2, S_RX = 4'd3, S_RXHOLD = 4'd4,
    S_RXACK = 4'd5, S_TXLOAD = 4'd6, S_TX = 4'd7, S_TXACK = 4'd8
  } state_e;

  logic [SYNC_LEN-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;
  logic [3:0] ctrl;
  logic [6:0] flags, ien, own;
  logic [7:0] dat, sh;
  logic [3:0] cnt;
  logic tx_full, rx_pend, ack_q, sda_drv;
  state_e state;

  wire scl_s   = scl_sync[SYNC_LEN-1];
  wire sda_s   = sda_sync[SYNC_LEN-1];
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire start   = scl_s & scl_q & sda_q & ~sda_s;
  wire stop    = scl_s & scl_q & ~sda_q & sda_s;
  wire en      = ctrl[2];
  wire data_wr = reg_we && reg_addr == A_DATA;

  assign sda_oe = sda_drv;
  assign irq    = |(flags & ien);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {4'b0, ctrl};
      A_STAT:  reg_rdata = {1'b0, flags};
      A_IEN:   reg_rdata = {1'b0, ien};
      A_OWN:   reg_rdata = {1'b0, own};
      A_DATA:  reg_rdata = dat;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1; sda_sync <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
      ctrl <= '0; flags <= '0; ien <= '0; own <= '0; dat <= '0; sh <= '0; cnt <= '0;
      tx_full <= 1'b0; rx_pend <= 1'b0; ack_q <= 1'b0; sda_drv <= 1'b0; scl_oe <= 1'b0;
      state <= S_IDLE;
    end else begin
      scl_sync <= {scl_sync[SYNC_LEN-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_LEN-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
      scl_oe <= en && (state == S_RXHOLD || state == S_TXLOAD);

      if (reg_we) begin
        case (reg_addr)
          A_CTRL: ctrl <= reg_wdata[3:0];
          A_STAT: flags <= {flags[6] & reg_wdata[6], flags[5], flags[4:0] & reg_wdata[4:0]};
          A_IEN:  ien <= reg_wdata[6:0];
          A_OWN:  own <= reg_wdata[6:0];
          default: ;
        endcase
      end
      if (data_wr) begin
        dat <= reg_wdata;
        tx_full <= 1'b1;
      end
      if (reg_re && reg_addr == A_DATA) rx_pend <= 1'b0;

      if (!en) begin
        state <= S_IDLE;
        sda_drv <= 1'b0;
      end else if (start) begin
        state <= S_ADDR;
        cnt <= '0;
        sda_drv <= 1'b0;
      end else if (stop) begin
        state <= S_IDLE;
        sda_drv <= 1'b0;
        flags[4] <= 1'b1;
      end else begin
        case (state)
          S_ADDR: begin
            if (rise) begin
              sh <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              if (sh[7:1] == own) begin
                flags[0] <= 1'b1; flags[5] <= sh[0];
                sda_drv <= 1'b1; state <= S_AACK;
              end else if (ctrl[1] && sh == 8'h00) begin
                flags[0] <= 1'b1; flags[6] <= 1'b1; flags[5] <= 1'b0;
                sda_drv <= 1'b1; state <= S_AACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_AACK: if (fall) begin
            sda_drv <= 1'b0;
            cnt <= '0;
            state <= flags[5] ? S_TXLOAD : S_RX;
          end
          S_RX: begin
            if (rise) begin
              sh <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              dat <= sh; flags[1] <= 1'b1; rx_pend <= 1'b1;
              state <= S_RXHOLD;
            end
          end
          S_RXHOLD: if (!rx_pend) begin
            sda_drv <= ~ctrl[0];
            state <= S_RXACK;
          end
          S_RXACK: if (fall) begin
            sda_drv <= 1'b0;
            cnt <= '0;
            state <= S_RX;
          end
          S_TXLOAD: if (tx_full) begin
            sh <= dat; tx_full <= 1'b0;
            sda_drv <= ~dat[7];
            cnt <= '0;
            state <= S_TX;
          end
          S_TX: begin
            if (rise) cnt <= cnt + 4'd1;
            else if (fall) begin
              if (cnt == 4'd8) begin
                sda_drv <= 1'b0;
                state <= S_TXACK;
              end else begin
                sh <= {sh[6:0], 1'b0};
                sda_drv <= ~sh[6];
              end
            end
          end
          S_TXACK: begin
            if (rise) begin
              flags[2] <= 1'b1;
              if (!sda_s) flags[3] <= 1'b1;
              ack_q <= ~sda_s;
            end else if (fall) begin
              state <= ack_q ? S_TXLOAD : S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_target_chk.sv
`timescale 1ns/1ps
module i2c_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       scl_s,
  input logic       scl_q,
  input logic       start_ev,
  input logic       stop_ev,
  input logic [6:0] flags,
  input logic [3:0] state,
  input logic       rx_pend,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       irq,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata
);
  localparam logic [3:0] HOLD_RX = 4'd4;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sda_oe && !scl_oe)); // R13
  AST_NO_GRAB_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && scl_s && scl_q && !sda_oe) |=> !sda_oe); // R5
  AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop_ev) |=> flags[4]); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd2 && reg_wdata == 8'h00) |=> !irq); // R12
  AST_RX_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == HOLD_RX && rx_pend && !start_ev && !stop_ev) |=> (state == HOLD_RX)); // R4
endmodule

bind i2c_target i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl[2]), .scl_s(scl_s), .scl_q(scl_q),
  .start_ev(start), .stop_ev(stop), .flags(flags), .state(state), .rx_pend(rx_pend),
  .sda_oe(sda_oe), .scl_oe(scl_oe), .irq(irq),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/sim_i2c_target.sv
`timescale 1ns/1ps
module sim_i2c_target;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, irq;
  wire scl_line = m_scl & ~scl_oe;
  wire sda_line = m_sda & ~sda_oe;
  int nchk = 0, nfail = 0, cyc = 0;
  localparam int HALF = 10;
  localparam logic [6:0] OWN = 7'h2A;

  always #10 clk = ~clk;

  i2c_target #(.SYNC_LEN(2)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic scl_high;
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start;
    m_sda = 1'b1; wait_cyc(HALF);
    scl_high; wait_cyc(HALF);
    m_sda = 1'b0; wait_cyc(HALF);
    m_scl = 1'b0; wait_cyc(HALF);
  endtask

  task automatic m_stop;
    m_sda = 1'b0; wait_cyc(HALF);
    scl_high; wait_cyc(HALF);
    m_sda = 1'b1; wait_cyc(HALF);
  endtask

  task automatic m_bit_w(input logic b);
    m_sda = b; wait_cyc(HALF);
    scl_high; wait_cyc(HALF);
    m_scl = 1'b0; wait_cyc(HALF);
  endtask

  task automatic m_bit_r(output logic b);
    m_sda = 1'b1; wait_cyc(HALF);
    scl_high; wait_cyc(HALF);
    b = sda_line;
    m_scl = 1'b0; wait_cyc(HALF);
  endtask

  task automatic m_byte_w(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_bit_w(v[i]);
  endtask

  task automatic m_byte_r(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_bit_r(b);
      v[i] = b;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], d);
      chk("R1 register after reset", d, 8'h00);
    end
    chk("R1 drivers and irq", {5'b0, scl_oe, sda_oe, irq}, 8'h00);
  endtask

  task automatic t_write_xfer;
    logic [7:0] d; logic b;
    m_start;
    m_byte_w({OWN, 1'b0});
    m_bit_r(b);
    chk("R2 address ack", {7'b0, b}, 8'h00);
    rd(3'd1, d);
    chk("R2 status after write address", d, 8'h01);
    m_byte_w(8'hA5);
    chk("R4 SCL held after byte", {7'b0, scl_oe}, 8'h01);
    rd(3'd1, d);
    chk("R4 data received flag", d & 8'h02, 8'h02);
    wait_cyc(60);
    chk("R4 SCL still held", {7'b0, scl_oe}, 8'h01);
    rd(3'd4, d);
    chk("R4 received byte", d, 8'hA5);
    wait_cyc(5);
    chk("R4 SCL released after read", {7'b0, scl_oe}, 8'h00);
    m_bit_r(b);
    chk("R5 ACK with forced NACK off", {7'b0, b}, 8'h00);
    wr(3'd0, 8'h0D);
    m_byte_w(8'h3C);
    rd(3'd4, d);
    chk("R4 second byte", d, 8'h3C);
    m_bit_r(b);
    chk("R5 NACK with forced NACK on", {7'b0, b}, 8'h01);
    m_stop;
    rd(3'd1, d);
    chk("R9 STOP flag", d & 8'h10, 8'h10);
    wr(3'd0, 8'h0C);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_mismatch;
    logic [7:0] d; logic b;
    m_start;
    m_byte_w({7'h2B, 1'b0});
    m_bit_r(b);
    chk("R3 foreign address NACKed", {7'b0, b}, 8'h01);
    m_byte_w(8'hF0);
    chk("R3 no stretch", {7'b0, scl_oe}, 8'h00);
    m_bit_r(b);
    m_stop;
    rd(3'd1, d);
    chk("R3 R9 only STOP flag set", d, 8'h10);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_read_xfer;
    logic [7:0] d; logic b;
    m_start;
    m_byte_w({OWN, 1'b1});
    m_bit_r(b);
    chk("R2 read address ack", {7'b0, b}, 8'h00);
    rd(3'd1, d);
    chk("R2 R6 transmit mode flag", d, 8'h21);
    chk("R6 stretch until data written", {7'b0, scl_oe}, 8'h01);
    wr(3'd4, 8'h96);
    wait_cyc(5);
    chk("R6 release after write", {7'b0, scl_oe}, 8'h00);
    m_byte_r(d);
    chk("R6 first byte MSB first", d, 8'h96);
    m_bit_w(1'b0);
    rd(3'd1, d);
    chk("R7 transmitted and empty flags", d, 8'h2D);
    chk("R7 stretch after master ACK", {7'b0, scl_oe}, 8'h01);
    wr(3'd1, 8'h00);
    rd(3'd1, d);
    chk("R11 transmit mode not cleared", d, 8'h20);
    wr(3'd4, 8'h5A);
    m_byte_r(d);
    chk("R7 second byte", d, 8'h5A);
    m_bit_w(1'b1);
    rd(3'd1, d);
    chk("R8 no empty flag after NACK", d, 8'h24);
    chk("R8 lines released", {6'b0, scl_oe, sda_oe}, 8'h00);
    m_stop;
    wr(3'd1, 8'h00);
  endtask

  task automatic t_gcall;
    logic [7:0] d; logic b;
    m_start;
    m_byte_w(8'h00);
    m_bit_r(b);
    chk("R10 general call ignored when off", {7'b0, b}, 8'h01);
    m_stop;
    rd(3'd1, d);
    chk("R10 no address flags", d & 8'h41, 8'h00);
    wr(3'd0, 8'h0E);
    m_start;
    m_byte_w(8'h00);
    m_bit_r(b);
    chk("R10 general call ACKed", {7'b0, b}, 8'h00);
    rd(3'd1, d);
    chk("R10 general call flags", d, 8'h51);
    m_byte_w(8'h11);
    rd(3'd4, d);
    chk("R10 general call data", d, 8'h11);
    m_bit_r(b);
    m_stop;
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(3'd2, 8'h00);
    chk("R12 irq masked", {7'b0, irq}, 8'h00);
    wr(3'd2, 8'h10);
    chk("R12 irq on enabled STOP flag", {7'b0, irq}, 8'h01);
    wr(3'd1, 8'hEF);
    rd(3'd1, d);
    chk("R11 selective clear", d, 8'h43);
    chk("R12 irq drops after clear", {7'b0, irq}, 8'h00);
    wr(3'd2, 8'h40);
    chk("R12 irq on general call flag", {7'b0, irq}, 8'h01);
    wr(3'd1, 8'h00);
    rd(3'd1, d);
    chk("R11 clear all", d, 8'h00);
    chk("R12 irq low when clear", {7'b0, irq}, 8'h00);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_disabled;
    logic [7:0] d; logic b;
    wr(3'd0, 8'h00);
    m_start;
    m_byte_w({OWN, 1'b0});
    m_bit_r(b);
    chk("R13 no ACK when disabled", {7'b0, b}, 8'h01);
    m_stop;
    rd(3'd1, d);
    chk("R13 no flags when disabled", d, 8'h00);
    chk("R13 no drive", {6'b0, scl_oe, sda_oe}, 8'h00);
  endtask

  initial begin
    wait_cyc(3);
    t_reset;
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset;
    wr(3'd3, {1'b0, OWN});
    wr(3'd0, 8'h0C);
    t_write_xfer;
    t_mismatch;
    t_read_xfer;
    t_gcall;
    t_irq;
    t_disabled;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule